// File: doc/BRIEF.md
# Lane Repair Multiplexer

This block gives a parallel credit-based link one spare wire to route around a single broken lane. The link bundle carries five control lanes (CRC, credit, reset, clock, valid) and a parameterised number of message lanes. On the transmit side, the block copies one chosen lane of the outgoing bundle onto the spare repair lane. On the receive side, it overwrites the chosen lane of the incoming bundle with the value arriving on the repair lane. Downstream logic then sees a complete bundle even if the chosen physical lane is dead.

Each direction has its own 8-bit select register. A select of 0 turns repair off. Codes 1 to 5 name the control lanes. Codes from 6 upward name message lanes. The select registers are written through simple write strobes. They accept a new value only while the link is not running, so a selection cannot change under live traffic. Both data paths are combinational from the registered selects. Detecting faulty lanes and choosing the select codes are left to other logic.

Top module: `lane_repair_mux`

## Requirements
- R1: After reset both select registers hold 0. The transmit repair lane is 0 and the receive bundle passes through unchanged.
- R2: A select write strobe seen at a rising clock edge while `link_active` is low loads that direction's register at that edge. The new code governs the outputs from then on.
- R3: A select write strobe seen while `link_active` is high is ignored, and the previous code stays in force.
- R4: With transmit select 0, `tx_repair` is 0 for every bundle value.
- R5: A transmit select code c with 1 <= c <= 5+MSG_W drives bundle bit c-1 onto `tx_repair`. The bundle bit order is: bit 0 CRC, bit 1 credit, bit 2 reset, bit 3 clock, bit 4 valid, bit 5+k message bit k. Code 6+k therefore picks message bit k.
- R6: A transmit select code above 5+MSG_W drives `tx_repair` to 0.
- R7: With receive select 0, `rx_fixed` equals `rx_bundle`.
- R8: A receive select code c with 1 <= c <= 5+MSG_W sets bit c-1 of `rx_fixed` to `rx_repair`. All other bits of `rx_fixed` equal `rx_bundle`. The bit order is the same as in R5.
- R9: A receive select code above 5+MSG_W leaves `rx_fixed` equal to `rx_bundle`.
- R10: Writing one direction's select never changes the behaviour of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_active | input | 1 | High while the link runs; blocks select writes |
| tx_sel_we | input | 1 | Write strobe for the transmit select |
| tx_sel_wdata | input | 8 | New transmit select code |
| rx_sel_we | input | 1 | Write strobe for the receive select |
| rx_sel_wdata | input | 8 | New receive select code |
| tx_bundle | input | 5+MSG_W | Outgoing bundle (control lanes in bits 4:0) |
| tx_repair | output | 1 | Spare lane driven toward the far end |
| rx_bundle | input | 5+MSG_W | Incoming bundle from the physical lanes |
| rx_repair | input | 1 | Spare lane arriving from the far end |
| rx_fixed | output | 5+MSG_W | Incoming bundle with the selected lane replaced |

## Verification
The bench builds the block with MSG_W = 4, which gives a 9-bit bundle. With that setting the in-range codes 1 to 9 and the out-of-range codes 10 to 255 both fit in a full sweep of all 256 select values in each direction. Every code is applied with several complementary bundle patterns and with both repair-lane levels. This exposes any lane that is picked or patched in the wrong position, any code that decodes wrongly at the range edges, and any leak between the two directions. Separate sequences try writes while the link is active and confirm that the old code keeps its effect.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  localparam int SEL_W      = 8;
  localparam int CTRL_LANES = 5;

  // Code 0 is "no repair". Codes 1..CTRL_LANES+msg_w each name one bundle bit.
  function automatic logic sel_in_range(input logic [SEL_W-1:0] sel, input int msg_w);
    return (sel != '0) && (int'(sel) <= CTRL_LANES + msg_w);
  endfunction

  // Bundle bit addressed by a select code (valid only when in range).
  function automatic int sel_to_pos(input logic [SEL_W-1:0] sel);
    return int'(sel) - 1;
  endfunction

endpackage

// File: rtl/lrm_sel_reg.sv
module lrm_sel_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic load;
  assign load = we && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= wdata;
  end

endmodule

// File: rtl/lrm_tx_tap.sv
module lrm_tx_tap
  import lrm_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic [SEL_W-1:0]            sel,
  input  logic [CTRL_LANES+MSG_W-1:0] bundle,
  output logic                        hit,
  output logic                        lane
);

  localparam int BW = CTRL_LANES + MSG_W;
  localparam int IW = $clog2(BW);

  logic [IW-1:0] pos;

  assign hit = sel_in_range(sel, MSG_W);
  assign pos = IW'(sel_to_pos(sel));

  always_comb begin
    lane = 1'b0;
    if (hit) lane = bundle[pos];
  end

endmodule

// File: rtl/lrm_rx_patch.sv
module lrm_rx_patch
  import lrm_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic [SEL_W-1:0]            sel,
  input  logic [CTRL_LANES+MSG_W-1:0] bundle,
  input  logic                        repair,
  output logic                        hit,
  output logic [CTRL_LANES+MSG_W-1:0] mask,
  output logic [CTRL_LANES+MSG_W-1:0] fixed
);

  localparam int BW = CTRL_LANES + MSG_W;
  localparam int IW = $clog2(BW);

  logic [IW-1:0] pos;

  assign hit = sel_in_range(sel, MSG_W);
  assign pos = IW'(sel_to_pos(sel));

  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign mask[i]  = hit && (pos == IW'(i));
    assign fixed[i] = mask[i] ? repair : bundle[i];
  end

endmodule

// File: rtl/lane_repair_mux.sv
module lane_repair_mux
  import lrm_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        link_active,
  input  logic                        tx_sel_we,
  input  logic [SEL_W-1:0]            tx_sel_wdata,
  input  logic                        rx_sel_we,
  input  logic [SEL_W-1:0]            rx_sel_wdata,
  input  logic [CTRL_LANES+MSG_W-1:0] tx_bundle,
  output logic                        tx_repair,
  input  logic [CTRL_LANES+MSG_W-1:0] rx_bundle,
  input  logic                        rx_repair,
  output logic [CTRL_LANES+MSG_W-1:0] rx_fixed
);

  localparam int BW = CTRL_LANES + MSG_W;

  logic [SEL_W-1:0] tx_sel_q;
  logic [SEL_W-1:0] rx_sel_q;
  logic             tx_hit;
  logic             rx_hit;
  logic [BW-1:0]    rx_mask;

  lrm_sel_reg #(.W(SEL_W)) u_tx_sel (
    .clk(clk), .rst_n(rst_n), .hold(link_active),
    .we(tx_sel_we), .wdata(tx_sel_wdata), .q(tx_sel_q)
  );

  lrm_sel_reg #(.W(SEL_W)) u_rx_sel (
    .clk(clk), .rst_n(rst_n), .hold(link_active),
    .we(rx_sel_we), .wdata(rx_sel_wdata), .q(rx_sel_q)
  );

  lrm_tx_tap #(.MSG_W(MSG_W)) u_tx (
    .sel(tx_sel_q), .bundle(tx_bundle), .hit(tx_hit), .lane(tx_repair)
  );

  lrm_rx_patch #(.MSG_W(MSG_W)) u_rx (
    .sel(rx_sel_q), .bundle(rx_bundle), .repair(rx_repair),
    .hit(rx_hit), .mask(rx_mask), .fixed(rx_fixed)
  );

endmodule

// File: rtl/lrm_chk.sv
module lrm_chk
  import lrm_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        link_active,
  input logic                        tx_sel_we,
  input logic [SEL_W-1:0]            tx_sel_wdata,
  input logic                        rx_sel_we,
  input logic [SEL_W-1:0]            rx_sel_wdata,
  input logic [SEL_W-1:0]            tx_sel,
  input logic [SEL_W-1:0]            rx_sel,
  input logic                        tx_hit,
  input logic                        rx_hit,
  input logic                        tx_repair,
  input logic [CTRL_LANES+MSG_W-1:0] rx_bundle,
  input logic [CTRL_LANES+MSG_W-1:0] rx_mask,
  input logic [CTRL_LANES+MSG_W-1:0] rx_fixed
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_sel == '0 && rx_sel == '0));

  // R2
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_active && tx_sel_we) |=> (tx_sel == $past(tx_sel_wdata)));

  // R2
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_active && rx_sel_we) |=> (rx_sel == $past(rx_sel_wdata)));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_active |=> ($stable(tx_sel) && $stable(rx_sel)));

  // R4 R6
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_hit |-> !tx_repair);

  // R7 R9
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_hit |-> (rx_fixed == rx_bundle));

  // R8
  rx_single_patch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_mask) && ($countones(rx_fixed ^ rx_bundle) <= 1));

endmodule

bind lane_repair_mux lrm_chk #(.MSG_W(MSG_W)) u_lrm_chk (
  .clk(clk), .rst_n(rst_n), .link_active(link_active),
  .tx_sel_we(tx_sel_we), .tx_sel_wdata(tx_sel_wdata),
  .rx_sel_we(rx_sel_we), .rx_sel_wdata(rx_sel_wdata),
  .tx_sel(tx_sel_q), .rx_sel(rx_sel_q),
  .tx_hit(tx_hit), .rx_hit(rx_hit), .tx_repair(tx_repair),
  .rx_bundle(rx_bundle), .rx_mask(rx_mask), .rx_fixed(rx_fixed)
);

// File: tb/test_lane_repair_mux.sv
module test_lane_repair_mux;

  localparam int MW = 4;
  localparam int BW = 5 + MW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          link_active = 1'b0;
  logic          tx_sel_we = 1'b0;
  logic [7:0]    tx_sel_wdata = '0;
  logic          rx_sel_we = 1'b0;
  logic [7:0]    rx_sel_wdata = '0;
  logic [BW-1:0] tx_bundle = '0;
  logic          tx_repair;
  logic [BW-1:0] rx_bundle = '0;
  logic          rx_repair = 1'b0;
  logic [BW-1:0] rx_fixed;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lane_repair_mux #(.MSG_W(MW)) i_lane_repair_mux (
    .clk(clk), .rst_n(rst_n), .link_active(link_active),
    .tx_sel_we(tx_sel_we), .tx_sel_wdata(tx_sel_wdata),
    .rx_sel_we(rx_sel_we), .rx_sel_wdata(rx_sel_wdata),
    .tx_bundle(tx_bundle), .tx_repair(tx_repair),
    .rx_bundle(rx_bundle), .rx_repair(rx_repair), .rx_fixed(rx_fixed)
  );

  localparam logic [BW-1:0] PATS [4] = '{9'h155, 9'h0AA, 9'h1FF, 9'h000};

  function automatic logic want_tx(input int code, input logic [BW-1:0] b);
    if (code >= 1 && code <= BW) return b[code-1];
    return 1'b0;
  endfunction

  function automatic logic [BW-1:0] want_rx(input int code, input logic [BW-1:0] b, input logic r);
    logic [BW-1:0] o;
    o = b;
    if (code >= 1 && code <= BW) o[code-1] = r;
    return o;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write at a negedge; the register loads at the following posedge.
  task automatic write_sel(input logic is_tx, input int code, input logic active);
    @(negedge clk);
    link_active = active;
    if (is_tx) begin tx_sel_we = 1'b1; tx_sel_wdata = 8'(code); end
    else       begin rx_sel_we = 1'b1; rx_sel_wdata = 8'(code); end
    @(negedge clk);
    tx_sel_we = 1'b0;
    rx_sel_we = 1'b0;
    link_active = 1'b0;
  endtask

  function automatic string tx_tag(input int code);
    if (code == 0) return "R4";
    if (code <= BW) return "R5";
    return "R6";
  endfunction

  function automatic string rx_tag(input int code);
    if (code == 0) return "R7";
    if (code <= BW) return "R8";
    return "R9";
  endfunction

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state seen at the ports
    tx_bundle = '1; rx_bundle = 9'h0F3; rx_repair = 1'b0;
    #2;
    check(tx_repair == 1'b0, "R1 tx", int'(tx_repair), 0);
    check(rx_fixed == rx_bundle, "R1 rx", int'(rx_fixed), int'(rx_bundle));

    // Transmit sweep over all codes (R2, R4, R5, R6); rx select stays 0 (R10)
    for (int c = 0; c < 256; c++) begin
      write_sel(1'b1, c, 1'b0);
      for (int p = 0; p < 4; p++) begin
        tx_bundle = PATS[p];
        rx_bundle = ~PATS[p]; rx_repair = PATS[p][0];
        #1;
        check(tx_repair == want_tx(c, tx_bundle), tx_tag(c), int'(tx_repair), int'(want_tx(c, tx_bundle)));
        check(rx_fixed == rx_bundle, "R10 rx", int'(rx_fixed), int'(rx_bundle));
      end
    end

    // Receive sweep over all codes (R2, R7, R8, R9); tx select holds 255 (R10)
    for (int c = 0; c < 256; c++) begin
      write_sel(1'b0, c, 1'b0);
      for (int p = 0; p < 4; p++) begin
        for (int r = 0; r < 2; r++) begin
          rx_bundle = PATS[p]; rx_repair = 1'(r);
          tx_bundle = '1;
          #1;
          check(rx_fixed == want_rx(c, rx_bundle, rx_repair), rx_tag(c),
                int'(rx_fixed), int'(want_rx(c, rx_bundle, rx_repair)));
          check(tx_repair == 1'b0, "R10 tx", int'(tx_repair), 0);
        end
      end
    end

    // R3: writes while the link is active leave the old code in force
    write_sel(1'b1, 3, 1'b0);             // tx picks reset lane, bit 2
    write_sel(1'b1, 0, 1'b1);             // ignored
    tx_bundle = 9'h004; #1;
    check(tx_repair == 1'b1, "R3 tx", int'(tx_repair), 1);
    tx_bundle = 9'h1FB; #1;
    check(tx_repair == 1'b0, "R3 tx", int'(tx_repair), 0);

    write_sel(1'b0, 6, 1'b0);             // rx patches message bit 0, bit 5
    write_sel(1'b0, 1, 1'b1);             // ignored
    rx_bundle = 9'h000; rx_repair = 1'b1; #1;
    check(rx_fixed == 9'h020, "R3 rx", int'(rx_fixed), 9'h020);

    // R2: the same write with the link idle does take effect
    write_sel(1'b0, 1, 1'b0);
    #1;
    check(rx_fixed == 9'h001, "R2 rx", int'(rx_fixed), 9'h001);

    // R10: changing tx select leaves rx patch position alone
    write_sel(1'b1, 9, 1'b0);
    #1;
    check(rx_fixed == 9'h001, "R10 rx", int'(rx_fixed), 9'h001);

    // R1: a second reset clears both selects
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    tx_bundle = '1; rx_bundle = 9'h0AA; rx_repair = 1'b1; #1;
    check(tx_repair == 1'b0, "R1 tx", int'(tx_repair), 0);
    check(rx_fixed == 9'h0AA, "R1 rx", int'(rx_fixed), 9'h0AA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule